// File: doc/BRIEF.md
# Nibble ALU with Flag Register

This block is the execute stage of a small 4-bit datapath. It takes two nibble operands, a 5-bit operation code and the carry currently held in its own flag register. In the same cycle it produces a nibble result and a no-writeback indication. Eighteen operations are decoded:

- arithmetic with carry in and borrow;
- bitwise operations;
- rotates through the carry;
- logical shifts.

Compare and the two bit-test forms compute flags only. For them the surrounding datapath must discard the result. Operand fetch, instruction decode and the destination write belong to the surrounding logic.

The flag register has four bits: zero in bit 0, carry in bit 1, interrupt enable in bit 2 and extension in bit 3. The zero and carry bits are updated on a clock edge when the execute strobe is high. The upper two bits are left untouched by every operation. A separate write port lets the datapath load all four bits directly, for example when it restores state. The active-low asynchronous reset clears the whole register.

Top module: `nalu_core`

## Requirements
- R1: Operation codes 0 (add) and 1 (add with carry) produce the low 4 bits of a+b or a+b+C, and the next carry is the fifth bit of that sum.
- R2: Codes 2 (subtract), 3 (subtract with borrow, a-b-C) and 4 (compare, a-b) produce the low 4 bits of the difference. The next carry is 1 exactly when the unsigned difference falls below zero.
- R3: Code 5 adds one to a and code 6 subtracts one from a; b is ignored. The next carry is set when a=15 for code 5, and when a=0 for code 6.
- R4: Codes 7 (and), 8 (or), 9 (xor), 10 (bit test, a and b), 11 (clear, a and not b), 12 (set, a or b) and 13 (test, a and b) compute their bitwise result and leave the carry flag unchanged.
- R5: no_wb_o is 1 for codes 4, 10 and 13 and 0 for every other code from 0 to 17. The flags of these three codes match those of subtract and of and.
- R6: Code 14 rotates left through carry: result {a[2:0],C}, next C=a[3]. Code 15 rotates right through carry: result {C,a[3:1]}, next C=a[0].
- R7: Code 16 shifts left and code 17 shifts right, filling the vacated bit with 0. The bit shifted out becomes the next carry.
- R8: For every defined code, the zero flag after an executed operation is 1 exactly when the 4-bit result is 0.
- R9: Flags change only on a clock edge with exec_i high, and bits 3 and 2 are never changed by an operation.
- R10: With fl_we_i high, the flag register loads fl_d_i on the clock edge, and this takes priority over exec_i.
- R11: Reset (rst_ni low) clears all four flag bits.
- R12: Codes 18 to 31 produce result 0 and no_wb_o=1, and an executed undefined code leaves all flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| exec_i | input | 1 | Execute strobe; commits Z and C on the edge |
| op_i | input | 5 | Operation code |
| a_i | input | 4 | First operand |
| b_i | input | 4 | Second operand |
| fl_we_i | input | 1 | Direct flag register load enable |
| fl_d_i | input | 4 | Flag register load value {E,I,C,Z} |
| res_o | output | 4 | Operation result |
| no_wb_o | output | 1 | Result must not be written back |
| flags_o | output | 4 | Flag register {E,I,C,Z} |

## Verification
The bench builds the block with its default nibble width of 4. At this width every boundary can be reached with literal operands:

- carry out of 15;
- borrow below 0;
- all-ones and all-zero results.

Before each vector, a direct flag load sets the incoming carry to both 0 and 1. This load also holds the upper flag bits at 1, so a stray write to them shows up at flags_o.

// File: rtl/nalu_pkg.sv
package nalu_pkg;
  localparam int OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 5'd0,  OP_ADC = 5'd1,  OP_SUB = 5'd2,  OP_SBC = 5'd3,
    OP_CMP = 5'd4,  OP_INC = 5'd5,  OP_DEC = 5'd6,  OP_AND = 5'd7,
    OP_OR  = 5'd8,  OP_XOR = 5'd9,  OP_BIT = 5'd10, OP_CLR = 5'd11,
    OP_SET = 5'd12, OP_TST = 5'd13, OP_RL  = 5'd14, OP_RR  = 5'd15,
    OP_SLL = 5'd16, OP_SRL = 5'd17
  } nalu_op_e;

  localparam int NUM_OPS = 18;

  // flag register bit positions
  localparam int FL_Z = 0;
  localparam int FL_C = 1;
  localparam int FL_I = 2;
  localparam int FL_E = 3;
  localparam int FL_W = 4;
endpackage

// File: rtl/nalu_arith.sv
module nalu_arith
  import nalu_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [OP_W-1:0] op_i,
  input  logic [W-1:0]    a_i,
  input  logic [W-1:0]    b_i,
  input  logic            c_i,
  output logic [W-1:0]    res_o,
  output logic            c_o,
  output logic            hit_o
);
  localparam int EW = W + 1;

  logic [EW-1:0] a_x, b_x, c_x, one_x, sum;

  assign a_x   = {1'b0, a_i};
  assign b_x   = {1'b0, b_i};
  assign c_x   = {{W{1'b0}}, c_i};
  assign one_x = {{W{1'b0}}, 1'b1};

  always_comb begin
    hit_o = 1'b1;
    case (op_i)
      OP_ADD:         sum = a_x + b_x;
      OP_ADC:         sum = a_x + b_x + c_x;
      OP_SUB, OP_CMP: sum = a_x - b_x;
      OP_SBC:         sum = a_x - b_x - c_x;
      OP_INC:         sum = a_x + one_x;
      OP_DEC:         sum = a_x - one_x;
      default: begin
        sum   = '0;
        hit_o = 1'b0;
      end
    endcase
  end

  // top bit is carry for sums and borrow for differences
  assign res_o = sum[W-1:0];
  assign c_o   = sum[W];
endmodule

// File: rtl/nalu_logic.sv
module nalu_logic
  import nalu_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [OP_W-1:0] op_i,
  input  logic [W-1:0]    a_i,
  input  logic [W-1:0]    b_i,
  input  logic            c_i,
  output logic [W-1:0]    res_o,
  output logic            c_o,
  output logic            hit_o
);
  always_comb begin
    hit_o = 1'b1;
    case (op_i)
      OP_AND, OP_BIT, OP_TST: res_o = a_i & b_i;
      OP_OR,  OP_SET:         res_o = a_i | b_i;
      OP_XOR:                 res_o = a_i ^ b_i;
      OP_CLR:                 res_o = a_i & ~b_i;
      default: begin
        res_o = '0;
        hit_o = 1'b0;
      end
    endcase
  end

  assign c_o = c_i;
endmodule

// File: rtl/nalu_shift.sv
module nalu_shift
  import nalu_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [OP_W-1:0] op_i,
  input  logic [W-1:0]    a_i,
  input  logic            c_i,
  output logic [W-1:0]    res_o,
  output logic            c_o,
  output logic            hit_o
);
  always_comb begin
    hit_o = 1'b1;
    case (op_i)
      OP_RL: begin
        res_o = {a_i[W-2:0], c_i};
        c_o   = a_i[W-1];
      end
      OP_RR: begin
        res_o = {c_i, a_i[W-1:1]};
        c_o   = a_i[0];
      end
      OP_SLL: begin
        res_o = {a_i[W-2:0], 1'b0};
        c_o   = a_i[W-1];
      end
      OP_SRL: begin
        res_o = {1'b0, a_i[W-1:1]};
        c_o   = a_i[0];
      end
      default: begin
        res_o = '0;
        c_o   = c_i;
        hit_o = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/nalu_flag_reg.sv
module nalu_flag_reg
  import nalu_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [FL_W-1:0] d_i,
  input  logic            upd_i,
  input  logic            z_i,
  input  logic            c_i,
  output logic [FL_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o <= '0;
    end else if (we_i) begin
      q_o <= d_i;
    end else if (upd_i) begin
      q_o[FL_Z] <= z_i;
      q_o[FL_C] <= c_i;
    end
  end
endmodule

// File: rtl/nalu_core.sv
module nalu_core
  import nalu_pkg::*;
#(
  parameter int W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            exec_i,
  input  logic [4:0]      op_i,
  input  logic [W-1:0]    a_i,
  input  logic [W-1:0]    b_i,
  input  logic            fl_we_i,
  input  logic [3:0]      fl_d_i,
  output logic [W-1:0]    res_o,
  output logic            no_wb_o,
  output logic [3:0]      flags_o
);
  logic [W-1:0] ar_res, lg_res, sh_res;
  logic         ar_c, lg_c, sh_c;
  logic         ar_hit, lg_hit, sh_hit;
  logic         any_hit, c_nx, z_nx, flag_only;
  logic         c_cur;

  assign c_cur = flags_o[FL_C];

  nalu_arith #(.W(W)) u_arith (
    .op_i (op_i), .a_i (a_i), .b_i (b_i), .c_i (c_cur),
    .res_o(ar_res), .c_o (ar_c), .hit_o(ar_hit)
  );

  nalu_logic #(.W(W)) u_logic (
    .op_i (op_i), .a_i (a_i), .b_i (b_i), .c_i (c_cur),
    .res_o(lg_res), .c_o (lg_c), .hit_o(lg_hit)
  );

  nalu_shift #(.W(W)) u_shift (
    .op_i (op_i), .a_i (a_i), .c_i (c_cur),
    .res_o(sh_res), .c_o (sh_c), .hit_o(sh_hit)
  );

  // units decode disjoint opcode ranges
  always_comb begin
    if (ar_hit) begin
      res_o = ar_res;
      c_nx  = ar_c;
    end else if (lg_hit) begin
      res_o = lg_res;
      c_nx  = lg_c;
    end else if (sh_hit) begin
      res_o = sh_res;
      c_nx  = sh_c;
    end else begin
      res_o = '0;
      c_nx  = c_cur;
    end
  end

  assign any_hit   = ar_hit | lg_hit | sh_hit;
  assign z_nx      = ~|res_o;
  assign flag_only = (op_i == OP_CMP) || (op_i == OP_BIT) || (op_i == OP_TST);
  assign no_wb_o   = flag_only | ~any_hit;

  nalu_flag_reg u_flags (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (fl_we_i),
    .d_i   (fl_d_i),
    .upd_i (exec_i & any_hit),
    .z_i   (z_nx),
    .c_i   (c_nx),
    .q_o   (flags_o)
  );
endmodule

// File: rtl/nalu_core_chk.sv
module nalu_core_chk
  import nalu_pkg::*;
#(
  parameter int W = 4
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         exec_i,
  input logic [4:0]   op_i,
  input logic [W-1:0] res_o,
  input logic         no_wb_o,
  input logic         fl_we_i,
  input logic [3:0]   fl_d_i,
  input logic [3:0]   flags_o
);
  logic is_logic, is_def;
  assign is_logic = (op_i >= 5'(OP_AND)) && (op_i <= 5'(OP_TST));
  assign is_def   = (op_i < 5'(NUM_OPS));

  p_ei_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fl_we_i |=> flags_o[3:2] == $past(flags_o[3:2]));

  p_idle_stable_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fl_we_i && !exec_i) |=> $stable(flags_o));

  p_load_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fl_we_i |=> flags_o == $past(fl_d_i));

  p_logic_keeps_c_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && !fl_we_i && is_logic) |=> flags_o[FL_C] == $past(flags_o[FL_C]));

  p_zero_flag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && !fl_we_i && is_def) |=> flags_o[FL_Z] == ($past(res_o) == '0));

  p_shift_fill_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 5'(OP_SLL)) |-> !res_o[0]);

  p_flag_only_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 5'(OP_CMP) || op_i == 5'(OP_BIT) || op_i == 5'(OP_TST)) |-> no_wb_o);

  p_undef_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !is_def |-> (no_wb_o && res_o == '0));

  p_undef_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!is_def && !fl_we_i) |=> $stable(flags_o));
endmodule

bind nalu_core nalu_core_chk #(.W(W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .exec_i (exec_i),
  .op_i   (op_i),
  .res_o  (res_o),
  .no_wb_o(no_wb_o),
  .fl_we_i(fl_we_i),
  .fl_d_i (fl_d_i),
  .flags_o(flags_o)
);

// File: tb/nalu_core_bench.sv
module nalu_core_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 4;
  localparam int NV = 30;

  // {op, a, b, cin, res, c, z, nowb}
  function automatic logic [20:0] v(input int op, input int a, input int b,
                                    input int ci, input int r, input int c,
                                    input int z, input int nw);
    return {5'(op), 4'(a), 4'(b), 1'(ci), 4'(r), 1'(c), 1'(z), 1'(nw)};
  endfunction

  localparam logic [20:0] VEC [NV] = '{
    v(0, 9, 8, 0, 1, 1, 0, 0),    // R1
    v(0, 8, 8, 0, 0, 1, 1, 0),    // R1 R8
    v(1, 7, 8, 1, 0, 1, 1, 0),    // R1
    v(1, 3, 4, 1, 8, 0, 0, 0),    // R1
    v(2, 5, 3, 1, 2, 0, 0, 0),    // R2
    v(2, 3, 5, 0, 14, 1, 0, 0),   // R2
    v(3, 5, 5, 1, 15, 1, 0, 0),   // R2
    v(3, 6, 2, 1, 3, 0, 0, 0),    // R2
    v(4, 4, 4, 1, 0, 0, 1, 1),    // R2 R5
    v(4, 2, 7, 0, 11, 1, 0, 1),   // R2 R5
    v(5, 15, 5, 0, 0, 1, 1, 0),   // R3
    v(5, 6, 9, 1, 7, 0, 0, 0),    // R3
    v(6, 0, 3, 0, 15, 1, 0, 0),   // R3
    v(6, 1, 0, 1, 0, 0, 1, 0),    // R3
    v(7, 12, 10, 1, 8, 1, 0, 0),  // R4
    v(8, 5, 10, 0, 15, 0, 0, 0),  // R4
    v(9, 6, 6, 1, 0, 1, 1, 0),    // R4
    v(10, 9, 6, 0, 0, 0, 1, 1),   // R4 R5
    v(11, 15, 5, 1, 10, 1, 0, 0), // R4
    v(12, 1, 8, 0, 9, 0, 0, 0),   // R4
    v(13, 14, 2, 1, 2, 1, 0, 1),  // R4 R5
    v(14, 9, 0, 0, 2, 1, 0, 0),   // R6
    v(14, 4, 0, 1, 9, 0, 0, 0),   // R6
    v(15, 1, 0, 0, 0, 1, 1, 0),   // R6
    v(15, 6, 0, 1, 11, 0, 0, 0),  // R6
    v(16, 12, 0, 0, 8, 1, 0, 0),  // R7
    v(16, 3, 0, 1, 6, 0, 0, 0),   // R7
    v(17, 3, 0, 0, 1, 1, 0, 0),   // R7
    v(17, 8, 0, 1, 4, 0, 0, 0),   // R7
    v(20, 7, 7, 1, 0, 1, 0, 1)    // R12
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         exec = 1'b0;
  logic [4:0]   op = '0;
  logic [W-1:0] a = '0, b = '0;
  logic         fl_we = 1'b0;
  logic [3:0]   fl_d = '0;
  logic [W-1:0] res;
  logic         no_wb;
  logic [3:0]   flags;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nalu_core #(.W(W)) u_nalu_core (
    .clk_i(clk), .rst_ni(rst_n), .exec_i(exec), .op_i(op), .a_i(a), .b_i(b),
    .fl_we_i(fl_we), .fl_d_i(fl_d), .res_o(res), .no_wb_o(no_wb), .flags_o(flags)
  );

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic load_flags(input logic [3:0] d);
    @(negedge clk);
    exec = 1'b0;
    fl_we = 1'b1;
    fl_d = d;
    @(negedge clk);
    fl_we = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R11 reset flags", flags, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [20:0] e;
      e = VEC[i];
      load_flags({2'b11, e[7], 1'b0});
      op = e[20:16];
      a = e[15:12];
      b = e[11:8];
      exec = 1'b1;
      #1;
      check($sformatf("R1-7/R12 vec%0d res", i), res, e[6:3]);
      check($sformatf("R5 vec%0d nowb", i), no_wb, e[0]);
      @(negedge clk);
      exec = 1'b0;
      check($sformatf("R8 R9 vec%0d flags", i), flags, {2'b11, e[2], e[1]});
    end

    // R9: no strobe, no change
    load_flags(4'b0100);
    op = 5'd0; a = 4'd8; b = 4'd8; exec = 1'b0;
    @(negedge clk);
    check("R9 idle flags", flags, 4'b0100);

    // R10: load beats execute
    op = 5'd0; a = 4'd8; b = 4'd8; exec = 1'b1;
    fl_we = 1'b1; fl_d = 4'b1000;
    @(negedge clk);
    fl_we = 1'b0; exec = 1'b0;
    check("R10 load priority", flags, 4'b1000);

    // R3: DEC ignores b
    load_flags(4'b0000);
    op = 5'd6; a = 4'd9; b = 4'd15; exec = 1'b1;
    #1;
    check("R3 dec ignores b", res, 8);
    @(negedge clk);
    exec = 1'b0;
    check("R3 dec flags", flags, 4'b0000);

    // R12: undefined code 31 keeps Z=1 C=0
    load_flags(4'b0001);
    op = 5'd31; a = 4'd3; b = 4'd3; exec = 1'b1;
    #1;
    check("R12 undef nowb", no_wb, 1);
    @(negedge clk);
    exec = 1'b0;
    check("R12 undef flags", flags, 4'b0001);

    // R11: async reset mid-run
    load_flags(4'b1111);
    #2 rst_n = 1'b0;
    #1;
    check("R11 async reset", flags, 0);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule